// File: doc/BRIEF.md
# Range-Wrapping Loadable Up-Counter

This block is a 4-bit synchronous binary up-counter with an enable, a synchronous parallel load, a synchronous clear and a carry output that marks the all-ones state. Internally the count is built from narrower counter slices. The slices are chained through their terminal-count outputs, so the block itself shows the same cascading rule that a wider counter built from several copies of it would follow.

Around the counter sits a range controller. It can bend the count sequence in three ways:
- When the start option is on, the counter reloads a programmable start value after the all-ones state.
- When the end option is on, the counter returns to zero after it reaches a programmable end value.
- When both are on, the counter runs from the start value up to the end value, and then goes back to the start value.

All controls are plain level signals sampled on the rising clock edge. There is no streaming data path, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `rng_counter`

## Requirements
- R1: With `cnt_en` high, and neither `clr` nor `ld` high, `count` rises by one on each rising edge. With `cnt_en` low, `count` holds its value.
- R2: With `ld` high and `clr` low, `count` takes `ld_data` on the edge. Bit 3 is the most significant bit and bit 0 the least.
- R3: With `clr` high, `count` becomes 0000 on the edge.
- R4: `carry` is high exactly when `count` is 1111.
- R5: When several controls are high together, `clr` wins over `ld`, and `ld` wins over counting and over any range action.
- R6: The upper slice (bits 3:2) advances only on an enabled counting cycle in which the lower slice (bits 1:0) is at 11.
- R7: With `use_start` and `use_end` both low, an enabled count at 1111 goes to 0000.
- R8: With only `use_start` high, an enabled count at 1111 goes to `start_val`. With a start of 0110 the sequence is 0110 through 1111, repeated.
- R9: With only `use_end` high, an enabled count equal to `end_val` goes to 0000. With an end of 1101 the sequence is 0000 through 1101, repeated.
- R10: With both options high and `end_val` >= `start_val`, an enabled count equal to `end_val` goes to `start_val`.
- R11: With both options high and `end_val` < `start_val`, the end value is ignored, and an enabled count at 1111 goes to `start_val`.
- R12: A range action (a reload of `start_val` or a return to zero) happens only on a cycle with `cnt_en` high. With `cnt_en` low, `count` holds even at 1111 or at `end_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| cnt_en | input | 1 | Count enable |
| ld | input | 1 | Synchronous parallel load |
| clr | input | 1 | Synchronous clear to zero |
| ld_data | input | 4 | Parallel load value, bit 3 most significant |
| start_val | input | 4 | Value reloaded when the start option wraps |
| end_val | input | 4 | Last value before the end option wraps |
| use_start | input | 1 | Enable the start-value reload |
| use_end | input | 1 | Enable the end-value wrap |
| count | output | 4 | Current count |
| carry | output | 1 | High while count is 1111 |

## Verification
The counter is driven in each option setting: free running, start only, end only, combined with the end at or above the start, and combined with the end below the start. Each setting leads to a different successor for the values 1111 and `end_val`, so swapping one wrap rule for another shows up as a wrong successor. A long free-running run passes every lower-slice rollover, which separates a correct cascade from one that carries on the wrong state. Stimuli with `clr`, `ld` and `cnt_en` applied together, and cycles with the enable low at 1111 or at `end_val`, separate the control priority and the gating of the wrap actions from plain counting.

// File: rtl/rng_counter_pkg.sv
package rng_counter_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_INC  = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/rng_cnt_slice.sv
module rng_cnt_slice #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          s_clr,
  input  logic          s_ld,
  input  logic [SW-1:0] s_ld_val,
  input  logic          s_inc,
  output logic [SW-1:0] s_q,
  output logic          s_tc
);
  logic [SW-1:0] q_r;

  always_ff @(posedge clk) begin
    if (s_clr)      q_r <= '0;
    else if (s_ld)  q_r <= s_ld_val;
    else if (s_inc) q_r <= q_r + 1'b1;
  end

  assign s_q  = q_r;
  assign s_tc = &q_r;

  logic armed = 1'b0;
  always_ff @(posedge clk) if (s_clr) armed <= 1'b1;

  // R6
  slice_idle_chk: assert property (@(posedge clk) disable iff (!armed)
    (!s_clr && !s_ld && !s_inc) |=> $stable(q_r));
endmodule

// File: rtl/rng_range_ctl.sv
module rng_range_ctl
  import rng_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic [W-1:0] cur,
  input  logic         cnt_en,
  input  logic         ld,
  input  logic         clr,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] start_val,
  input  logic [W-1:0] end_val,
  input  logic         use_start,
  input  logic         use_end,
  output cnt_act_e     act,
  output logic [W-1:0] act_val
);
  logic at_top, inverted, end_hit;

  assign at_top   = &cur;
  assign inverted = use_start && (end_val < start_val);
  assign end_hit  = use_end && !inverted && (cur == end_val);

  always_comb begin
    act     = ACT_HOLD;
    act_val = ld_data;
    if (clr) begin
      act = ACT_CLR;
    end else if (ld) begin
      act = ACT_LOAD;
    end else if (cnt_en) begin
      if (end_hit) begin
        if (use_start) begin
          act     = ACT_LOAD;
          act_val = start_val;
        end else begin
          act = ACT_CLR;
        end
      end else if (at_top && use_start) begin
        act     = ACT_LOAD;
        act_val = start_val;
      end else begin
        act = ACT_INC;
      end
    end
  end

  // R12
  disabled_hold_chk: assert property (@(posedge clk)
    (!clr && !ld && !cnt_en) |-> (act == ACT_HOLD));
endmodule

// File: rtl/rng_counter.sv
module rng_counter
  import rng_counter_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int SLICE_W = 2
) (
  input  logic             clk,
  input  logic             cnt_en,
  input  logic             ld,
  input  logic             clr,
  input  logic [WIDTH-1:0] ld_data,
  input  logic [WIDTH-1:0] start_val,
  input  logic [WIDTH-1:0] end_val,
  input  logic             use_start,
  input  logic             use_end,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  localparam int NSL = WIDTH / SLICE_W;

  cnt_act_e         act;
  logic [WIDTH-1:0] act_val;
  logic [NSL-1:0]   tc;
  logic [NSL:0]     chain;

  rng_range_ctl #(.W(WIDTH)) u_ctl (
    .clk(clk), .cur(count), .cnt_en(cnt_en), .ld(ld), .clr(clr),
    .ld_data(ld_data), .start_val(start_val), .end_val(end_val),
    .use_start(use_start), .use_end(use_end),
    .act(act), .act_val(act_val)
  );

  assign chain[0] = (act == ACT_INC);

  for (genvar k = 0; k < NSL; k++) begin : g_slice
    rng_cnt_slice #(.SW(SLICE_W)) u_slice (
      .clk(clk),
      .s_clr(act == ACT_CLR),
      .s_ld(act == ACT_LOAD),
      .s_ld_val(act_val[k*SLICE_W +: SLICE_W]),
      .s_inc(chain[k]),
      .s_q(count[k*SLICE_W +: SLICE_W]),
      .s_tc(tc[k])
    );
    assign chain[k+1] = chain[k] & tc[k];
  end

  assign carry = &tc;

  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!armed && !clr)
    clr |=> (count == '0));
  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!armed)
    (ld && !clr) |=> (count == $past(ld_data)));
  // R1
  idle_stable_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && !cnt_en) |=> $stable(count));
  // R4
  carry_match_chk: assert property (@(posedge clk) disable iff (!armed)
    carry == (count == '1));
  // R7
  free_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && cnt_en && !use_start && !use_end && carry) |=> (count == '0));
endmodule

// File: tb/test_rng_counter.sv
module test_rng_counter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic cnt_en = 0, ld = 0, clr = 1, use_start = 0, use_end = 0;
  logic [3:0] ld_data = 0, start_val = 0, end_val = 0;
  logic [3:0] count;
  logic carry;
  int checks = 0, errors = 0;
  int model = 0;

  rng_counter i_rng_counter (
    .clk(clk), .cnt_en(cnt_en), .ld(ld), .clr(clr), .ld_data(ld_data),
    .start_val(start_val), .end_val(end_val), .use_start(use_start),
    .use_end(use_end), .count(count), .carry(carry)
  );

  function automatic int next_val(int m);
    if (clr) return 0;
    if (ld) return int'(ld_data);
    if (!cnt_en) return m;
    if (use_end && !(use_start && end_val < start_val) && m == int'(end_val))
      return use_start ? int'(start_val) : 0;
    if (m == 15) return use_start ? int'(start_val) : 0;
    return m + 1;
  endfunction

  task automatic cyc(input logic e, input logic l, input logic c, input string tag);
    cnt_en = e; ld = l; clr = c;
    model = next_val(model);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (int'(count) != model) begin
      errors++;
      $display("FAIL %s count actual=%0d expected=%0d", tag, count, model);
    end
    checks++;
    if (carry != (model == 15)) begin
      errors++;
      $display("FAIL R4 (%s) carry actual=%0b expected=%0b", tag, carry, model == 15);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(0, 0, 1, "R3");                                   // reset state
    for (int i = 0; i < 40; i++) cyc(1, 0, 0, "R1_R6_R7"); // free run, rollovers
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, "R1");        // hold
    ld_data = 4'b1010; cyc(0, 1, 0, "R2");
    ld_data = 4'b0101; cyc(1, 1, 0, "R5");                 // load beats count
    ld_data = 4'b1111; cyc(1, 1, 1, "R5");                 // clear beats load
    // start only
    use_start = 1; start_val = 4'b0110;
    for (int i = 0; i < 25; i++) cyc(1, 0, 0, "R8");
    ld_data = 4'b1111; cyc(0, 1, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, "R12");       // holds at 1111
    cyc(1, 0, 0, "R8");
    // end only
    use_start = 0; use_end = 1; end_val = 4'b1101;
    cyc(0, 0, 1, "R3");
    for (int i = 0; i < 30; i++) cyc(1, 0, 0, "R9");
    ld_data = 4'b1101; cyc(0, 1, 0, "R2");
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, "R12");       // holds at end
    cyc(1, 0, 0, "R9");
    // combined, end above start
    use_start = 1; start_val = 4'd3; end_val = 4'd9;
    for (int i = 0; i < 25; i++) cyc(1, 0, 0, "R10");
    // combined, end below start
    start_val = 4'd12; end_val = 4'd5;
    cyc(0, 0, 1, "R3");
    for (int i = 0; i < 30; i++) cyc(1, 0, 0, "R11");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule